// File: doc/BRIEF.md
# Memory ECC Event Capture and Injection Register Block

This block sits next to the ECC checker of a memory controller. It records what went wrong on the read path. It also lets test software corrupt the write path on purpose. The checker reports each event as a one-cycle pulse. The pulse carries a single-bit or multi-bit indication, together with the 64-bit data word, the 8-bit check byte and the full error address it saw.

Multi-bit events raise a sticky flag at once. Single-bit events pass through a counter first, and raise their flag only when the count reaches a programmed threshold. Flags are cleared by writing one to them. The details of the event that first raised a flag stay frozen until software has cleared every flag. An interrupt line goes high while any flag is set whose enable is also set.

On the write path, two 32-bit data masks and an 8-bit check mask XOR the outgoing word and its check bits. This happens only while injection is armed, and it is combinational.

Top module: `ecc_evt_regs`

## Requirements
- R1: After reset every register reads 0 and `irq` is 0.
- R2: A multi-bit event that is not disabled sets flag bit 1 of the status word (address 0) at the next clock edge. A pulse carrying both indications also feeds the single-bit counter.
- R3: Each single-bit event that is not disabled adds one to the count in bits 7:0 of the counter word (address 3). When the new count reaches a nonzero threshold held in bits 23:16, flag bit 0 is set and the count returns to 0. With a threshold of 0 the count stops at 255 and no flag is set. A register write to that word takes priority over an event in the same cycle.
- R4: Writing the status word clears each flag whose data bit is 1 and leaves the others alone. Writing all ones clears every flag. An event that sets a flag in the same cycle as its clear leaves the flag set.
- R5: When an event sets a flag while no flag is set, the capture words load in the same edge: data bits 63:32 at address 4, data bits 31:0 at address 5, the check byte at address 6 (bits 7:0), address bits 31:0 at address 7, and the upper address bits, zero-extended, at address 8. While any flag is set they hold.
- R6: In the mask word (address 1), bit 0 blocks single-bit events and bit 1 blocks multi-bit events. A blocked event changes no flag, count or capture word. Writing 0 unblocks both.
- R7: `irq` is high exactly while some flag is set whose enable bit is also set. The enable word is at address 2: bit 0 enables single-bit, bit 1 enables multi-bit.
- R8: The injection word at address 11 has an arm bit (bit 8) and a check mask (bits 7:0). The high data mask is at address 9 and the low data mask at address 10. While armed, `wp_data_out` = `wp_data_in` XOR {high mask, low mask} and `wp_chk_out` = `wp_chk_in` XOR the check mask. Otherwise both pass through unchanged, in the same cycle.
- R9: A read presents the word at `rd_addr` on `rd_data` at the clock edge that samples `rd_en`. Addresses 12 to 15 read 0. The mask, enable and injection words read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 32 | Registered read data |
| evt_valid | input | 1 | Checker event pulse |
| evt_sbe | input | 1 | Event is a single-bit error |
| evt_mbe | input | 1 | Event is a multi-bit error |
| evt_data | input | 64 | Data word seen by the checker |
| evt_chk | input | 8 | Check byte seen by the checker |
| evt_addr | input | EADDR_W | Error address |
| wp_data_in | input | 64 | Write-path data before injection |
| wp_chk_in | input | 8 | Write-path check bits before injection |
| wp_data_out | output | 64 | Write-path data after injection |
| wp_chk_out | output | 8 | Write-path check bits after injection |
| irq | output | 1 | Interrupt request |

## Verification
Flags, the count, the capture words, the mask words and `irq` all change at the first rising edge after the write or event pulse is presented. `irq` is decoded straight from the flag and enable registers, so it needs no extra cycle. A read result appears at the edge that samples `rd_en`, so a status read issued after the event edge shows the new state. The injection outputs follow their inputs within the same cycle. The bench drives every input on the falling edge and samples one falling edge later, which is half a period after the edge where each result becomes due.

// File: rtl/ecc_evt_pkg.sv
package ecc_evt_pkg;
  localparam int REG_AW  = 4;
  localparam int WORD_W  = 32;
  localparam int DATA_W  = 64;
  localparam int CHK_W   = 8;
  localparam int CNT_W   = 8;
  localparam int NFLAG   = 2;
  localparam int THR_LSB = 16;
  localparam int ARM_BIT = 8;

  typedef enum logic [REG_AW-1:0] {
    RA_STATUS  = 4'd0,
    RA_MASK    = 4'd1,
    RA_ENABLE  = 4'd2,
    RA_COUNTER = 4'd3,
    RA_CAP_DHI = 4'd4,
    RA_CAP_DLO = 4'd5,
    RA_CAP_CHK = 4'd6,
    RA_CAP_ALO = 4'd7,
    RA_CAP_AHI = 4'd8,
    RA_INJ_HI  = 4'd9,
    RA_INJ_LO  = 4'd10,
    RA_INJ_CTL = 4'd11
  } reg_addr_e;
endpackage

// File: rtl/ecc_evt_sbe_cnt.sv
module ecc_evt_sbe_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sbe_hit,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_cnt,
  input  logic [CW-1:0] cfg_thr,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] thr_q,
  output logic          sbe_trip
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [CW-1:0] cnt_d, thr_d;
  logic [CW:0]   cnt_inc;
  logic          cnt_en;

  always_comb begin
    cnt_inc  = {1'b0, cnt_q} + 1'b1;
    cnt_d    = cnt_q;
    thr_d    = thr_q;
    sbe_trip = 1'b0;
    cnt_en   = cfg_we | sbe_hit;
    if (cfg_we) begin
      cnt_d = cfg_cnt;
      thr_d = cfg_thr;
    end else if (sbe_hit) begin
      if (thr_q != '0 && cnt_inc >= {1'b0, thr_q}) begin
        sbe_trip = 1'b1;
        cnt_d    = '0;
      end else if (cnt_q != CNT_MAX) begin
        cnt_d = cnt_inc[CW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      thr_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      thr_q <= thr_d;
    end
  end

  p_trip_clears_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sbe_trip |=> (cnt_q == '0));
  p_zero_thr_saturates_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sbe_hit && !cfg_we && thr_q == '0 && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/ecc_evt_capture.sv
module ecc_evt_capture #(
  parameter int NF = 2,
  parameter int DW = 64,
  parameter int CW = 8,
  parameter int AW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] flag_set,
  input  logic          clr_we,
  input  logic [NF-1:0] clr_bits,
  input  logic [DW-1:0] evt_data,
  input  logic [CW-1:0] evt_chk,
  input  logic [AW-1:0] evt_addr,
  output logic [NF-1:0] flags_q,
  output logic [DW-1:0] cap_data_q,
  output logic [CW-1:0] cap_chk_q,
  output logic [AW-1:0] cap_addr_q
);
  logic [NF-1:0] flags_d;
  logic          flags_en, cap_load;

  always_comb begin
    flags_en = clr_we | (|flag_set);
    flags_d  = (flags_q & ~(clr_we ? clr_bits : '0)) | flag_set;
    cap_load = (|flag_set) && (flags_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_data_q <= '0;
      cap_chk_q  <= '0;
      cap_addr_q <= '0;
    end else if (cap_load) begin
      cap_data_q <= evt_data;
      cap_chk_q  <= evt_chk;
      cap_addr_q <= evt_addr;
    end
  end

  p_set_beats_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set[NF-1] |=> flags_q[NF-1]);
  p_capture_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q != '0) |=> ($stable(cap_data_q) && $stable(cap_addr_q) && $stable(cap_chk_q)));
  p_first_event_loads_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|flag_set) && flags_q == '0) |=> (cap_chk_q == $past(evt_chk)));
endmodule

// File: rtl/ecc_evt_inject.sv
module ecc_evt_inject #(
  parameter int DW = 64,
  parameter int CW = 8
) (
  input  logic          arm,
  input  logic [DW-1:0] data_mask,
  input  logic [CW-1:0] chk_mask,
  input  logic [DW-1:0] data_in,
  input  logic [CW-1:0] chk_in,
  output logic [DW-1:0] data_out,
  output logic [CW-1:0] chk_out
);
  always_comb begin
    data_out = data_in ^ (arm ? data_mask : '0);
    chk_out  = chk_in ^ (arm ? chk_mask : '0);
  end
endmodule

// File: rtl/ecc_evt_regs.sv
module ecc_evt_regs
  import ecc_evt_pkg::*;
#(
  parameter int EADDR_W = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [REG_AW-1:0]    wr_addr,
  input  logic [WORD_W-1:0]    wr_data,
  input  logic                 rd_en,
  input  logic [REG_AW-1:0]    rd_addr,
  output logic [WORD_W-1:0]    rd_data,
  input  logic                 evt_valid,
  input  logic                 evt_sbe,
  input  logic                 evt_mbe,
  input  logic [DATA_W-1:0]    evt_data,
  input  logic [CHK_W-1:0]     evt_chk,
  input  logic [EADDR_W-1:0]   evt_addr,
  input  logic [DATA_W-1:0]    wp_data_in,
  input  logic [CHK_W-1:0]     wp_chk_in,
  output logic [DATA_W-1:0]    wp_data_out,
  output logic [CHK_W-1:0]     wp_chk_out,
  output logic                 irq
);
  localparam int INJ_W = ARM_BIT + 1;

  logic [NFLAG-1:0]   mask_q, mask_d, enable_q, enable_d, flags_q, flag_set;
  logic [WORD_W-1:0]  inj_hi_q, inj_hi_d, inj_lo_q, inj_lo_d;
  logic [INJ_W-1:0]   inj_ctl_q, inj_ctl_d;
  logic [CNT_W-1:0]   cnt_q, thr_q;
  logic [DATA_W-1:0]  cap_data_q;
  logic [CHK_W-1:0]   cap_chk_q;
  logic [EADDR_W-1:0] cap_addr_q;
  logic [63:0]        cap_addr_ext;
  logic [WORD_W-1:0]  rd_mux;
  logic               we_status, we_mask, we_enable, we_counter;
  logic               we_inj_hi, we_inj_lo, we_inj_ctl;
  logic               sbe_hit, sbe_trip, mbe_hit;
  logic               unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[31:24], wr_data[15:9]};

  // write decode
  always_comb begin
    we_status  = wr_en && (wr_addr == RA_STATUS);
    we_mask    = wr_en && (wr_addr == RA_MASK);
    we_enable  = wr_en && (wr_addr == RA_ENABLE);
    we_counter = wr_en && (wr_addr == RA_COUNTER);
    we_inj_hi  = wr_en && (wr_addr == RA_INJ_HI);
    we_inj_lo  = wr_en && (wr_addr == RA_INJ_LO);
    we_inj_ctl = wr_en && (wr_addr == RA_INJ_CTL);
    mask_d     = wr_data[NFLAG-1:0];
    enable_d   = wr_data[NFLAG-1:0];
    inj_hi_d   = wr_data;
    inj_lo_d   = wr_data;
    inj_ctl_d  = wr_data[INJ_W-1:0];
  end

  // event qualification
  always_comb begin
    sbe_hit  = evt_valid && evt_sbe && !mask_q[0];
    mbe_hit  = evt_valid && evt_mbe && !mask_q[1];
    flag_set = {mbe_hit, sbe_trip};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (we_mask) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) enable_q <= '0;
    else if (we_enable) enable_q <= enable_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inj_hi_q <= '0;
    else if (we_inj_hi) inj_hi_q <= inj_hi_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inj_lo_q <= '0;
    else if (we_inj_lo) inj_lo_q <= inj_lo_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inj_ctl_q <= '0;
    else if (we_inj_ctl) inj_ctl_q <= inj_ctl_d;
  end

  ecc_evt_sbe_cnt #(.CW(CNT_W)) u_sbe_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .sbe_hit  (sbe_hit),
    .cfg_we   (we_counter),
    .cfg_cnt  (wr_data[CNT_W-1:0]),
    .cfg_thr  (wr_data[THR_LSB +: CNT_W]),
    .cnt_q    (cnt_q),
    .thr_q    (thr_q),
    .sbe_trip (sbe_trip)
  );

  ecc_evt_capture #(.NF(NFLAG), .DW(DATA_W), .CW(CHK_W), .AW(EADDR_W)) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .flag_set   (flag_set),
    .clr_we     (we_status),
    .clr_bits   (wr_data[NFLAG-1:0]),
    .evt_data   (evt_data),
    .evt_chk    (evt_chk),
    .evt_addr   (evt_addr),
    .flags_q    (flags_q),
    .cap_data_q (cap_data_q),
    .cap_chk_q  (cap_chk_q),
    .cap_addr_q (cap_addr_q)
  );

  ecc_evt_inject #(.DW(DATA_W), .CW(CHK_W)) u_inject (
    .arm       (inj_ctl_q[ARM_BIT]),
    .data_mask ({inj_hi_q, inj_lo_q}),
    .chk_mask  (inj_ctl_q[CHK_W-1:0]),
    .data_in   (wp_data_in),
    .chk_in    (wp_chk_in),
    .data_out  (wp_data_out),
    .chk_out   (wp_chk_out)
  );

  assign irq = |(flags_q & enable_q);

  // read path
  always_comb begin
    cap_addr_ext = 64'(cap_addr_q);
    rd_mux = '0;
    case (rd_addr)
      RA_STATUS:  rd_mux = WORD_W'(flags_q);
      RA_MASK:    rd_mux = WORD_W'(mask_q);
      RA_ENABLE:  rd_mux = WORD_W'(enable_q);
      RA_COUNTER: rd_mux = {8'h00, thr_q, 8'h00, cnt_q};
      RA_CAP_DHI: rd_mux = cap_data_q[63:32];
      RA_CAP_DLO: rd_mux = cap_data_q[31:0];
      RA_CAP_CHK: rd_mux = WORD_W'(cap_chk_q);
      RA_CAP_ALO: rd_mux = cap_addr_ext[31:0];
      RA_CAP_AHI: rd_mux = cap_addr_ext[63:32];
      RA_INJ_HI:  rd_mux = inj_hi_q;
      RA_INJ_LO:  rd_mux = inj_lo_q;
      RA_INJ_CTL: rd_mux = WORD_W'(inj_ctl_q);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags_q != '0));
  p_masked_mbe_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && mask_q[1] && !flags_q[1]) |=> !flags_q[1]);
  p_unarmed_passthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !inj_ctl_q[ARM_BIT] |-> (wp_data_out == wp_data_in && wp_chk_out == wp_chk_in));
  p_hole_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr >= 4'd12) |=> (rd_data == '0));
endmodule

// File: tb/ecc_evt_regs_bench.sv
module ecc_evt_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        evt_valid = 1'b0, evt_sbe = 1'b0, evt_mbe = 1'b0;
  logic [63:0] evt_data = '0;
  logic [7:0]  evt_chk = '0;
  logic [39:0] evt_addr = '0;
  logic [63:0] wp_data_in = '0;
  logic [7:0]  wp_chk_in = '0;
  logic [63:0] wp_data_out;
  logic [7:0]  wp_chk_out;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ecc_evt_regs #(.EADDR_W(40)) u_ecc_evt_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .evt_valid(evt_valid), .evt_sbe(evt_sbe), .evt_mbe(evt_mbe),
    .evt_data(evt_data), .evt_chk(evt_chk), .evt_addr(evt_addr),
    .wp_data_in(wp_data_in), .wp_chk_in(wp_chk_in),
    .wp_data_out(wp_data_out), .wp_chk_out(wp_chk_out), .irq(irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic event_pulse(input logic s, input logic m, input logic [63:0] d,
                             input logic [7:0] c, input logic [39:0] a);
    @(negedge clk);
    evt_valid = 1'b1; evt_sbe = s; evt_mbe = m;
    evt_data = d; evt_chk = c; evt_addr = a;
    @(negedge clk);
    evt_valid = 1'b0; evt_sbe = 1'b0; evt_mbe = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [3:0] a, input logic [31:0] e);
    logic [31:0] v;
    reg_rd(a, v);
    check(req, {32'h0, v}, {32'h0, e});
  endtask

  task automatic t_reset;
    for (int i = 0; i < 12; i++) expect_reg("R1 reset value", 4'(i), 32'h0);
    check("R1 irq after reset", {63'h0, irq}, 64'h0);
  endtask

  task automatic t_mbe_capture;
    reg_wr(4'd2, 32'h2);
    event_pulse(1'b0, 1'b1, 64'hDEAD_BEEF_0123_4567, 8'h5C, 40'hAB_1234_5678);
    check("R7 irq on enabled multi-bit flag", {63'h0, irq}, 64'h1);
    expect_reg("R2 multi-bit flag", 4'd0, 32'h2);
    expect_reg("R5 capture data high", 4'd4, 32'hDEAD_BEEF);
    expect_reg("R5 capture data low", 4'd5, 32'h0123_4567);
    expect_reg("R5 capture check", 4'd6, 32'h5C);
    expect_reg("R5 capture addr low", 4'd7, 32'h1234_5678);
    expect_reg("R5 capture addr high", 4'd8, 32'hAB);
  endtask

  task automatic t_w1c;
    reg_wr(4'd0, 32'h1);
    expect_reg("R4 zero bit leaves flag", 4'd0, 32'h2);
    reg_wr(4'd0, 32'h2);
    expect_reg("R4 one bit clears flag", 4'd0, 32'h0);
    check("R7 irq drops after clear", {63'h0, irq}, 64'h0);
  endtask

  task automatic t_threshold;
    reg_wr(4'd3, 32'h0003_0000);
    event_pulse(1'b1, 1'b0, 64'h1111_1111_2222_2222, 8'h01, 40'h00_0000_1000);
    event_pulse(1'b1, 1'b0, 64'h3333_3333_4444_4444, 8'h02, 40'h00_0000_2000);
    expect_reg("R3 count below threshold", 4'd3, 32'h0003_0002);
    expect_reg("R3 no flag below threshold", 4'd0, 32'h0);
    event_pulse(1'b1, 1'b0, 64'h5555_5555_6666_6666, 8'h03, 40'h12_0000_3000);
    expect_reg("R3 flag at threshold", 4'd0, 32'h1);
    expect_reg("R3 count cleared at threshold", 4'd3, 32'h0003_0000);
    expect_reg("R5 capture of tripping event", 4'd5, 32'h6666_6666);
    event_pulse(1'b0, 1'b1, 64'h7777_7777_8888_8888, 8'h04, 40'h34_0000_4000);
    expect_reg("R2 second flag sets", 4'd0, 32'h3);
    expect_reg("R5 capture held data", 4'd4, 32'h5555_5555);
    expect_reg("R5 capture held addr high", 4'd8, 32'h12);
    reg_wr(4'd0, 32'hFFFF_FFFF);
    expect_reg("R4 all ones clears", 4'd0, 32'h0);
  endtask

  task automatic t_zero_threshold;
    reg_wr(4'd3, 32'h0000_00FE);
    for (int i = 0; i < 3; i++)
      event_pulse(1'b1, 1'b0, 64'h0, 8'h0, 40'h0);
    expect_reg("R3 zero threshold saturates", 4'd3, 32'h0000_00FF);
    expect_reg("R3 zero threshold no flag", 4'd0, 32'h0);
  endtask

  task automatic t_mask;
    reg_wr(4'd3, 32'h0001_0000);
    reg_wr(4'd1, 32'h3);
    event_pulse(1'b1, 1'b1, 64'h9, 8'h9, 40'h9);
    expect_reg("R6 masked events no flag", 4'd0, 32'h0);
    expect_reg("R6 masked single-bit not counted", 4'd3, 32'h0001_0000);
    expect_reg("R6 masked event no capture", 4'd6, 32'h03);
    reg_wr(4'd1, 32'h0);
    event_pulse(1'b1, 1'b0, 64'hA, 8'hAA, 40'hA);
    expect_reg("R6 unmasked single-bit flag", 4'd0, 32'h1);
    check("R7 single-bit flag not enabled", {63'h0, irq}, 64'h0);
    reg_wr(4'd2, 32'h1);
    check("R7 single-bit flag enabled", {63'h0, irq}, 64'h1);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd0; wr_data = 32'h3;
    evt_valid = 1'b1; evt_mbe = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; evt_valid = 1'b0; evt_mbe = 1'b0;
    expect_reg("R4 set wins over clear", 4'd0, 32'h2);
    reg_wr(4'd0, 32'h3);
  endtask

  task automatic t_inject;
    reg_wr(4'd9, 32'hF000_000F);
    reg_wr(4'd10, 32'h0000_FF00);
    reg_wr(4'd11, 32'h0A5);
    @(negedge clk);
    wp_data_in = 64'h0123_4567_89AB_CDEF; wp_chk_in = 8'h3C;
    #1;
    check("R8 unarmed data passes", wp_data_out, 64'h0123_4567_89AB_CDEF);
    check("R8 unarmed check passes", {56'h0, wp_chk_out}, {56'h0, 8'h3C});
    reg_wr(4'd11, 32'h1A5);
    #1;
    check("R8 armed data flipped", wp_data_out, 64'h0123_4567_89AB_CDEF ^ 64'hF000_000F_0000_FF00);
    check("R8 armed check flipped", {56'h0, wp_chk_out}, {56'h0, 8'h3C ^ 8'hA5});
  endtask

  task automatic t_readback;
    expect_reg("R9 high mask readback", 4'd9, 32'hF000_000F);
    expect_reg("R9 injection word readback", 4'd11, 32'h1A5);
    expect_reg("R9 enable readback", 4'd2, 32'h1);
    expect_reg("R9 unmapped reads zero", 4'd14, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mbe_capture();
    t_w1c();
    t_threshold();
    t_zero_threshold();
    t_mask();
    t_same_cycle();
    t_inject();
    t_readback();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule